// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for a PHY's management register file behind a 32-bit command/status register. The host writes a command word that holds an interrupt-enable flag, an opcode, a PHY address, a register index and 16 bits of data. The block keeps the command for one clock, then acts on it. It updates or reads one of seven 16-bit PHY registers and applies that register's own side effect. It then overwrites the command/status register with a completion word: the ready flag is set and the result sits in the low half.

The completion also pulses a strobe for the interrupt logic. When the command asked for it, a management interrupt request pulses at the same time. A host read of the command/status register only sets the ready flag. Only one PHY address is emulated. Commands aimed at any other address complete without touching state, and the result half echoes the data the host wrote.

Top module: `mgmt_regfile_responder`

## Requirements
- R1: Command field positions: bit 29 is interrupt enable, bits 27:26 are the opcode, bits 25:21 are the PHY address, bits 20:16 are the register index and bits 15:0 are the data. One clock after `host_wr` is sampled, `ctl_q` becomes the command word with bit 28 set and bits 15:0 replaced by the result, and `done_o` pulses for exactly that one cycle.
- R2: Opcode 1 is a write and opcode 2 is a read. With opcode 0 or 3, `ctl_q` holds the raw written word with bit 28 unchanged, `done_o` stays low and no PHY register changes.
- R3: With a PHY address other than `PHY_ADDR` (default 1), no register changes, the command still completes with bit 28 set, and bits 15:0 echo the command data.
- R4: A write or read of register 0 with data bit 15 set reloads registers 0 and 1 from their defaults. For a write, the result is the default of register 0.
- R5: A write of register 0 with data bit 15 clear stores the data with bit 9 cleared, and returns that value.
- R6: Writes to register 1 change nothing, and the result is register 1's current value.
- R7: Registers 2 to 6 store written data and return it as the write result. Reads of registers 0, 2, 3 and 4 return the stored value unchanged.
- R8: A read of register 1 first ORs 0x0026 into it, then returns the new value.
- R9: A read of register 5 sets it to 0x41FE, and a read of register 6 sets it to 0x0001. Each read returns the forced value.
- R10: Register indices 7 to 31 store nothing, and their result is 0x0000.
- R11: `irq_o` pulses together with `done_o` exactly when the completed command had bit 29 set.
- R12: `host_rd` without `host_wr` sets bit 28 of `ctl_q` at the next edge and leaves all other bits as they were.
- R13: Reset clears `ctl_q`, `done_o` and `irq_o`, and loads every PHY register from `DEFAULTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the command/status register |
| host_wdata | input | 32 | Command word written by the host |
| host_rd | input | 1 | Host read strobe for the command/status register |
| ctl_q | output | 32 | Current command/status register value |
| done_o | output | 1 | One-cycle completion strobe |
| irq_o | output | 1 | One-cycle management interrupt request |

## Verification
The side effects that reach past the addressed register are the hardest to see from the ports. A reset through register 0 also restores register 1, but every read of register 1 ORs in bits of its own. The bench therefore first drives register 1 to a known value, then triggers the register-0 reset, and then reads register 1 back. It compares the result against a model that applies the same OR. Commands that should have no effect, such as dropped opcodes, foreign PHY addresses and register-1 writes, are each followed by read-back sweeps through the normal command path. A host read after a dropped opcode shows on its own that the ready flag can be set without a completion.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int CMD_W      = 32;
   localparam int REG_W      = 16;
   localparam int FLD_W      = 5;
   localparam int NUM_PREGS  = 7;
   localparam int BIT_IE     = 29;
   localparam int BIT_READY  = 28;
   localparam int OP_HI      = 27;
   localparam int PHY_HI     = 25;
   localparam int IDX_HI     = 20;
   localparam int CTRL_RST_BIT  = 15;
   localparam int CTRL_ANEG_BIT = 9;
   localparam logic [REG_W-1:0] STAT_DONE_MASK = 16'h0026;
   localparam logic [REG_W-1:0] LP_FORCED      = 16'h41FE;
   localparam logic [REG_W-1:0] EXP_FORCED     = 16'h0001;

   typedef enum logic [1:0] {
      OPC_NONE0 = 2'd0,
      OPC_WRITE = 2'd1,
      OPC_READ  = 2'd2,
      OPC_NONE3 = 2'd3
   } mgmt_op_e;

   typedef struct packed {
      logic              ie;
      mgmt_op_e          op;
      logic [FLD_W-1:0]  phy;
      logic [FLD_W-1:0]  idx;
      logic [REG_W-1:0]  data;
   } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
   import mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic             pend_vld,
   input  logic [CMD_W-1:0] pend_word,
   output mgmt_cmd_t        cmd,
   output logic             op_ok,
   output logic             apply,
   output logic             foreign
);
   logic addr_hit;

   always_comb begin
      cmd.ie   = pend_word[BIT_IE];
      cmd.op   = mgmt_op_e'(pend_word[OP_HI -: 2]);
      cmd.phy  = pend_word[PHY_HI -: FLD_W];
      cmd.idx  = pend_word[IDX_HI -: FLD_W];
      cmd.data = pend_word[REG_W-1:0];
   end

   assign addr_hit = (cmd.phy == FLD_W'(PHY_ADDR));
   assign op_ok    = pend_vld && ((cmd.op == OPC_WRITE) || (cmd.op == OPC_READ));
   assign apply    = op_ok && addr_hit;
   assign foreign  = op_ok && !addr_hit;
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mgmt_pkg::*;
#(
   parameter logic [NUM_PREGS*REG_W-1:0] DEFAULTS = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             apply,
   input  mgmt_cmd_t        cmd,
   output logic [REG_W-1:0] result
);
   logic [NUM_PREGS-1:0][REG_W-1:0] regs_q;
   logic [NUM_PREGS-1:0][REG_W-1:0] regs_d;
   logic is_wr;
   logic is_rd;

   assign is_wr = (cmd.op == OPC_WRITE);
   assign is_rd = (cmd.op == OPC_READ);

   function automatic logic [REG_W-1:0] dflt(input int n);
      return DEFAULTS[n*REG_W +: REG_W];
   endfunction

   always_comb begin
      regs_d = regs_q;
      result = '0;
      if (apply) begin
         case (cmd.idx)
            5'd0: begin
               if (cmd.data[CTRL_RST_BIT]) begin
                  regs_d[0] = dflt(0);
                  regs_d[1] = dflt(1);
               end else if (is_wr) begin
                  regs_d[0] = cmd.data & ~(REG_W'(1) << CTRL_ANEG_BIT);
               end
               result = regs_d[0];
            end
            5'd1: begin
               if (is_rd) regs_d[1] = regs_q[1] | STAT_DONE_MASK;
               result = regs_d[1];
            end
            5'd2, 5'd3, 5'd4: begin
               if (is_wr) regs_d[cmd.idx[2:0]] = cmd.data;
               result = regs_d[cmd.idx[2:0]];
            end
            5'd5: begin
               regs_d[5] = is_wr ? cmd.data : LP_FORCED;
               result = regs_d[5];
            end
            5'd6: begin
               regs_d[6] = is_wr ? cmd.data : EXP_FORCED;
               result = regs_d[6];
            end
            default: result = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) regs_q <= DEFAULTS;
      else     regs_q <= regs_d;
   end

   assert_status_wr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
      (apply && is_wr && cmd.idx == 5'd1) |=> (regs_q[1] == $past(regs_q[1])));
   assert_restart_cleared_R5: assert property (@(posedge clk) disable iff (rst)
      (apply && is_wr && cmd.idx == 5'd0 && !cmd.data[CTRL_RST_BIT]) |=> !regs_q[0][CTRL_ANEG_BIT]);
   assert_lp_forced_R9: assert property (@(posedge clk) disable iff (rst)
      (apply && is_rd && cmd.idx == 5'd5) |=> (regs_q[5] == LP_FORCED));
   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (apply && is_rd && cmd.idx == 5'd1) |=> ((regs_q[1] & STAT_DONE_MASK) == STAT_DONE_MASK));
endmodule

// File: rtl/mgmt_completion.sv
module mgmt_completion
   import mgmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             host_wr,
   input  logic [CMD_W-1:0] host_wdata,
   input  logic             host_rd,
   input  logic             op_ok,
   input  logic             foreign,
   input  logic             cmd_ie,
   input  logic [REG_W-1:0] cmd_data,
   input  logic [REG_W-1:0] reg_result,
   output logic             pend_vld,
   output logic [CMD_W-1:0] pend_word,
   output logic [CMD_W-1:0] ctl_q,
   output logic             done_o,
   output logic             irq_o
);
   logic [REG_W-1:0] res_sel;
   logic [CMD_W-1:0] done_word;

   assign res_sel   = foreign ? cmd_data : reg_result;
   assign done_word = {pend_word[CMD_W-1:BIT_READY+1], 1'b1,
                       pend_word[BIT_READY-1:REG_W], res_sel};

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_vld  <= 1'b0;
         pend_word <= '0;
         ctl_q     <= '0;
         done_o    <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         pend_vld <= host_wr;
         if (host_wr) pend_word <= host_wdata;
         done_o <= op_ok;
         irq_o  <= op_ok && cmd_ie;
         if (op_ok)        ctl_q <= done_word;
         else if (host_wr) ctl_q <= host_wdata;
         else if (host_rd) ctl_q[BIT_READY] <= 1'b1;
      end
   end

   assert_done_ready_R1: assert property (@(posedge clk) disable iff (rst)
      done_o |-> ctl_q[BIT_READY]);
   assert_irq_with_done_R11: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> done_o);
   assert_drop_no_done_R2: assert property (@(posedge clk) disable iff (rst)
      (pend_vld && !op_ok) |=> !done_o);
   assert_rd_sets_ready_R12: assert property (@(posedge clk) disable iff (rst)
      (host_rd && !host_wr && !pend_vld) |=> ctl_q[BIT_READY]);
endmodule

// File: rtl/mgmt_regfile_responder.sv
module mgmt_regfile_responder
   import mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 1,
   parameter logic [NUM_PREGS*REG_W-1:0] DEFAULTS =
      {16'h0000, 16'h0000, 16'h05E1, 16'h0154, 16'h02A8, 16'h7809, 16'h3000}
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        host_wr,
   input  logic [31:0] host_wdata,
   input  logic        host_rd,
   output logic [31:0] ctl_q,
   output logic        done_o,
   output logic        irq_o
);
   localparam int PHY_LIMIT = 1 << FLD_W;

   generate
      if (PHY_ADDR < 0 || PHY_ADDR >= PHY_LIMIT) begin : g_bad_phy
         $error("PHY_ADDR outside the address field range");
      end
      if (CMD_W != 32) begin : g_bad_cmd
         $error("command register must be 32 bits");
      end
   endgenerate

   logic             pend_vld;
   logic [CMD_W-1:0] pend_word;
   mgmt_cmd_t        cmd;
   logic             op_ok;
   logic             apply;
   logic             foreign;
   logic [REG_W-1:0] reg_result;

   mgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_decode (
      .pend_vld  (pend_vld),
      .pend_word (pend_word),
      .cmd       (cmd),
      .op_ok     (op_ok),
      .apply     (apply),
      .foreign   (foreign)
   );

   mgmt_phy_regs #(.DEFAULTS(DEFAULTS)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .apply  (apply),
      .cmd    (cmd),
      .result (reg_result)
   );

   mgmt_completion u_cpl (
      .clk        (clk),
      .rst        (rst),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rd    (host_rd),
      .op_ok      (op_ok),
      .foreign    (foreign),
      .cmd_ie     (cmd.ie),
      .cmd_data   (cmd.data),
      .reg_result (reg_result),
      .pend_vld   (pend_vld),
      .pend_word  (pend_word),
      .ctl_q      (ctl_q),
      .done_o     (done_o),
      .irq_o      (irq_o)
   );

   assert_cpl_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
      (host_wr && (host_wdata[27:26] == 2'd1 || host_wdata[27:26] == 2'd2)) |=> ##1 done_o);
endmodule

// File: tb/mgmt_regfile_responder_tb.sv
module mgmt_regfile_responder_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [31:0] ctl_q;
   logic        done_o;
   logic        irq_o;

   localparam logic [111:0] DEFS =
      {16'h0000, 16'h0000, 16'h05E1, 16'h0154, 16'h02A8, 16'h7809, 16'h3000};

   int tests = 0;
   int fails = 0;
   logic [15:0] mdl [7];

   always #2 clk = ~clk;

   mgmt_regfile_responder u_dut (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .ctl_q(ctl_q), .done_o(done_o), .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] dv(input int n);
      return DEFS[n*16 +: 16];
   endfunction

   // Bench model: returns expected result and updates mdl.
   task automatic model(input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] idx, input logic [15:0] d,
                        output logic [15:0] res);
      if (phy != 5'd1) begin res = d; return; end
      res = 16'h0000;
      if (idx == 0) begin
         if (d[15]) begin mdl[0] = dv(0); mdl[1] = dv(1); end
         else if (op == 2'd1) mdl[0] = d & 16'hFDFF;
         res = mdl[0];
      end else if (idx == 1) begin
         if (op == 2'd2) mdl[1] = mdl[1] | 16'h0026;
         res = mdl[1];
      end else if (idx <= 4) begin
         if (op == 2'd1) mdl[idx] = d;
         res = mdl[idx];
      end else if (idx <= 6) begin
         if (op == 2'd1) mdl[idx] = d;
         else mdl[idx] = (idx == 5) ? 16'h41FE : 16'h0001;
         res = mdl[idx];
      end
   endtask

   task automatic run_cmd(input string req, input logic ie, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] d);
      logic [31:0] w;
      logic [15:0] res;
      w = {2'b00, ie, 1'b0, op, phy, idx, d};
      @(negedge clk); host_wr = 1'b1; host_wdata = w;
      @(negedge clk); host_wr = 1'b0;
      @(negedge clk);
      if (op == 2'd1 || op == 2'd2) begin
         model(op, phy, idx, d, res);
         check({req, " word"}, ctl_q, {w[31:29], 1'b1, w[27:16], res});
         check({req, " done R1"}, {31'd0, done_o}, 32'd1);
         check({req, " irq R11"}, {31'd0, irq_o}, {31'd0, ie});
      end else begin
         check({req, " raw R2"}, ctl_q, w);
         check({req, " nodone R2"}, {30'd0, done_o, irq_o}, 32'd0);
      end
   endtask

   task automatic read_all(input string req);
      for (int i = 0; i < 8; i++) run_cmd(req, 1'b0, 2'd2, 5'd1, 5'(i), 16'h0000);
   endtask

   initial begin
      #400000;
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 7; i++) mdl[i] = DEFS[i*16 +: 16];
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R13 reset ctl", ctl_q, 32'd0);
      check("R13 reset strobes", {30'd0, done_o, irq_o}, 32'd0);
      read_all("R13 R8 R9 R10 defaults");

      // Writes to every index, then read back
      for (int i = 0; i < 8; i++)
         run_cmd("R5 R6 R7 R10 write", i[0], 2'd1, 5'd1, 5'(i), 16'h2600 + 16'(i) * 16'h0111);
      read_all("R7 R8 R9 R10 readback");

      // Register-0 reset by write restores reg 0 and 1
      run_cmd("R7 prep reg2", 1'b0, 2'd1, 5'd1, 5'd2, 16'hBEEF);
      run_cmd("R4 write reset", 1'b1, 2'd1, 5'd1, 5'd0, 16'h8000);
      read_all("R4 after write reset");
      run_cmd("R5 reg0 value", 1'b0, 2'd1, 5'd1, 5'd0, 16'h7FFF);
      run_cmd("R4 read reset", 1'b0, 2'd2, 5'd1, 5'd0, 16'h8000);
      run_cmd("R4 reg1 after read reset", 1'b0, 2'd2, 5'd1, 5'd1, 16'h0000);

      // Foreign PHY sweep
      for (int p = 0; p < 32; p++)
         run_cmd("R3 phy sweep", p[1], 2'd1, 5'(p), 5'd3, 16'(p) * 16'h0101);
      read_all("R3 after phy sweep");

      // Dropped opcodes and host read
      run_cmd("R2 op0", 1'b1, 2'd0, 5'd1, 5'd4, 16'h1234);
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
      check("R12 host read", ctl_q, {2'b00, 1'b1, 1'b1, 2'd0, 5'd1, 5'd4, 16'h1234});
      check("R12 host read no done", {31'd0, done_o}, 32'd0);
      run_cmd("R2 op3", 1'b0, 2'd3, 5'd1, 5'd2, 16'h5555);
      read_all("R2 state unchanged");

      // Interrupt enable on reads
      for (int i = 0; i < 7; i++) run_cmd("R11 ie read", 1'b1, 2'd2, 5'd1, 5'(i), 16'h0000);

      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule